// File: doc/BRIEF.md
# SPI Flash User-Mode Memory Window

This block lets a host reach serial flash devices through a plain register/memory bus. The host bus space splits in two. The lower half holds the control words: one shared configuration word, and one control word for each chip select. The upper half is a data window, and each chip select owns its own slice of that window. A load or store to a chip's slice becomes a run of raw SPI byte transfers, one transfer per byte of the access. The block never composes flash commands. Software frames each command itself by moving the chip out of its stop state, streaming opcode, address and data bytes through the window, and then setting the stop bit again.

Window accesses pass only when two conditions hold. The target chip's mode field must hold the user encoding. A store also needs that chip's write-enable bit in the configuration word. An access that fails these checks completes at once and causes no SPI traffic, and a refused load returns all ones. The SPI side runs in mode 0 with a clock divider set by a parameter. The host sees ready low while bytes are shifting and then a single-cycle ready pulse.

Top module: `spi_window_bridge`

## Requirements
- R1: After reset every chip-select line is high, ready and SCLK are low, and every control word and the configuration word read as zero.
- R2: A register store updates the word and a later register load returns it. Word 0 is the configuration word, with the write-enable bit for chip k at bit 16+k. Word 1+k is chip k's control word, with mode at bits [1:0] and the stop bit at bit 2. Register word w is at byte address 4*w with address bit 7 clear.
- R3: A window load of N bytes (N = 1..4) to a chip in user mode (mode 2'b11) makes exactly N SPI byte transfers, and each sends 0x00.
- R4: Load data is assembled little-endian. The first byte received lands in bits [7:0], the next in [15:8], and so on. Bytes above N read as zero.
- R5: A window store of N bytes makes exactly N transfers, starting with bits [7:0] of the write data and moving up one byte at a time.
- R6: A window store is carried out only if the configuration bit at 16 plus the chip index is set. Otherwise it completes with no SPI clocking.
- R7: A window store to a chip whose mode is not 2'b11 completes with no SPI clocking, even when that chip is write-enabled.
- R8: A window load from a chip whose mode is not 2'b11 returns 0xFFFFFFFF and produces no SPI clocking.
- R9: A chip's select line is driven low only while its mode is 2'b11 and its stop bit is clear. It is high in every other case.
- R10: SPI runs in mode 0. SCLK idles low, each byte goes out MSB first, and MISO is sampled on each rising SCLK edge. Each SCLK phase lasts CLK_DIV clock cycles.
- R11: Ready stays low while bytes shift and then pulses high for exactly one cycle, with load data valid in that cycle.
- R12: A window access with a size field outside 1..4 makes no SPI transfer, and a load of that kind returns 0xFFFFFFFF.
- R13: Chip k's window slice is selected by address bit 7 set and address bit 6 equal to k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request, held until ready |
| bus_write | input | 1 | 1 for store, 0 for load |
| bus_addr | input | ADDR_W | Byte address (bit 7 selects the window) |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Store data, least significant byte first on SPI |
| bus_rdata | output | 32 | Load data, valid while ready is high |
| bus_ready | output | 1 | Single-cycle completion pulse |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The bench models a mode-0 SPI device that logs every byte it receives and returns a known pattern. With that model it checks byte order in both directions. A design with a reversed order would return swapped load lanes, or send the top store byte first. The refused-access cases are the write-disabled chip, the non-user chip and the illegal size. For each of them the bench checks that the transfer count stays at zero and that loads return all ones; a leaky gate would show up as stray clocking. The bench also checks the write-enable bit position per chip, select-line framing by the stop bit, and the single-cycle ready pulse. Its latency check catches a ready that is raised before all bits have shifted.

// File: rtl/spi_win_pkg.sv
package spi_win_pkg;
  localparam logic [1:0] MODE_USER     = 2'b11;
  localparam int         CTRL_STOP_BIT = 2;
  localparam int         WORD_W        = 32;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LAUNCH, SQ_WAIT, SQ_RESP} seq_state_e;
  typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH} shf_state_e;
endpackage

// File: rtl/spi_win_regs.sv
module spi_win_regs
  import spi_win_pkg::*;
#(
  parameter int NUM_CS  = 2,
  parameter int WE_BASE = 16,
  parameter int IDX_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic [NUM_CS-1:0] user_mode,
  output logic [NUM_CS-1:0] wr_allow,
  output logic [NUM_CS-1:0] cs_n
);
  logic [NUM_CS-1:0][1:0] mode_q, mode_d;
  logic [NUM_CS-1:0]      stop_q, stop_d;
  logic [NUM_CS-1:0]      we_q, we_d;
  logic                   unused_wr;

  assign unused_wr = ^wr_data;

  always_comb begin
    mode_d = mode_q;
    stop_d = stop_q;
    we_d   = we_q;
    if (wr_en) begin
      if (idx == '0) begin
        we_d = wr_data[WE_BASE +: NUM_CS];
      end
      for (int k = 0; k < NUM_CS; k++) begin
        if (idx == IDX_W'(k + 1)) begin
          mode_d[k] = wr_data[1:0];
          stop_d[k] = wr_data[CTRL_STOP_BIT];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      stop_q <= '0;
      we_q   <= '0;
    end else begin
      mode_q <= mode_d;
      stop_q <= stop_d;
      we_q   <= we_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (idx == '0) begin
      rd_data[WE_BASE +: NUM_CS] = we_q;
    end
    for (int k = 0; k < NUM_CS; k++) begin
      if (idx == IDX_W'(k + 1)) begin
        rd_data[1:0]          = mode_q[k];
        rd_data[CTRL_STOP_BIT] = stop_q[k];
      end
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_chip
    assign user_mode[g] = (mode_q[g] == MODE_USER);
    assign wr_allow[g]  = we_q[g];
    assign cs_n[g]      = !(user_mode[g] && !stop_q[g]);
  end

  // R2: a configuration store is visible on the next cycle
  assert_cfg_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == '0) |=> (we_q == $past(wr_data[WE_BASE +: NUM_CS])));
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_win_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

  shf_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic [7:0]       rx_q, rx_d;
  logic             sclk_q, sclk_d;
  logic             done_q, done_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    sclk_d = sclk_q;
    done_d = 1'b0;
    unique case (st_q)
      SH_IDLE: begin
        if (start) begin
          sh_d  = tx_byte;
          bit_d = '0;
          cnt_d = '0;
          st_d  = SH_LOW;
        end
      end
      SH_LOW: begin
        if (cnt_q == CNT_LAST) begin
          cnt_d  = '0;
          sclk_d = 1'b1;
          rx_d   = {rx_q[6:0], miso};
          st_d   = SH_HIGH;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SH_HIGH: begin
        if (cnt_q == CNT_LAST) begin
          cnt_d  = '0;
          sclk_d = 1'b0;
          if (bit_q == 3'd7) begin
            st_d   = SH_IDLE;
            done_d = 1'b1;
          end else begin
            bit_d = bit_q + 1'b1;
            sh_d  = {sh_q[6:0], 1'b0};
            st_d  = SH_LOW;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
    end
  end

  assign busy    = (st_q != SH_IDLE);
  assign sclk    = sclk_q;
  assign mosi    = busy & sh_q[7];
  assign done    = done_q;
  assign rx_byte = rx_q;

  // R10: SCLK rests low whenever no byte is in flight
  assert_sclk_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  // R10: a byte ends on a falling SCLK edge
  assert_done_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(sclk) && !sclk));
endmodule

// File: rtl/spi_win_seq.sv
module spi_win_seq
  import spi_win_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int ADDR_W = 8,
  parameter int CS_W   = 1,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_size,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_ready,
  input  logic [NUM_CS-1:0] user_mode,
  input  logic [NUM_CS-1:0] wr_allow,
  input  logic [WORD_W-1:0] reg_rdata,
  output logic              reg_wr_en,
  output logic [IDX_W-1:0]  reg_idx,
  input  logic              shf_busy,
  input  logic              shf_done,
  input  logic [7:0]        shf_rx,
  output logic              shf_start,
  output logic [7:0]        shf_tx
);
  seq_state_e        st_q, st_d;
  logic [2:0]        size_q, size_d;
  logic [1:0]        idx_q, idx_d;
  logic              wr_q, wr_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;

  logic              is_win, chip_user, chip_we, size_ok, go;
  logic [CS_W-1:0]   chip_idx;
  logic              unused_addr;

  assign unused_addr = ^bus_addr;
  assign is_win   = bus_addr[ADDR_W-1];
  assign chip_idx = bus_addr[ADDR_W-2 -: CS_W];
  assign reg_idx  = bus_addr[IDX_W+1:2];
  assign size_ok  = (bus_size != 3'd0) && (bus_size <= 3'd4);

  always_comb begin
    chip_user = 1'b0;
    chip_we   = 1'b0;
    for (int k = 0; k < NUM_CS; k++) begin
      if (chip_idx == CS_W'(k)) begin
        chip_user = user_mode[k];
        chip_we   = wr_allow[k];
      end
    end
  end

  assign go = size_ok && chip_user && (!bus_write || chip_we);

  always_comb begin
    st_d      = st_q;
    size_d    = size_q;
    idx_d     = idx_q;
    wr_d      = wr_q;
    data_d    = data_q;
    rdata_d   = rdata_q;
    reg_wr_en = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (bus_valid) begin
          if (!is_win) begin
            reg_wr_en = bus_write;
            rdata_d   = bus_write ? '0 : reg_rdata;
            st_d      = SQ_RESP;
          end else if (go) begin
            size_d  = bus_size;
            wr_d    = bus_write;
            data_d  = bus_wdata;
            idx_d   = '0;
            rdata_d = '0;
            st_d    = SQ_LAUNCH;
          end else begin
            rdata_d = bus_write ? '0 : '1;
            st_d    = SQ_RESP;
          end
        end
      end
      SQ_LAUNCH: st_d = SQ_WAIT;
      SQ_WAIT: begin
        if (shf_done) begin
          rdata_d[{idx_q, 3'b000} +: 8] = wr_q ? 8'h00 : shf_rx;
          if ({1'b0, idx_q} == size_q - 3'd1) begin
            st_d = SQ_RESP;
          end else begin
            idx_d = idx_q + 1'b1;
            st_d  = SQ_LAUNCH;
          end
        end
      end
      SQ_RESP: st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      size_q  <= '0;
      idx_q   <= '0;
      wr_q    <= 1'b0;
      data_q  <= '0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      size_q  <= size_d;
      idx_q   <= idx_d;
      wr_q    <= wr_d;
      data_q  <= data_d;
      rdata_q <= rdata_d;
    end
  end

  assign shf_start = (st_q == SQ_LAUNCH);
  assign shf_tx    = wr_q ? data_q[{idx_q, 3'b000} +: 8] : 8'h00;
  assign bus_ready = (st_q == SQ_RESP);
  assign bus_rdata = rdata_q;

  // R11: completion is a single-cycle pulse
  assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);
  // R11: no completion while a byte is still shifting
  assert_ready_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    shf_busy |-> !bus_ready);
  // R10: a new byte is launched only into an idle shifter
  assert_start_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    shf_start |-> !shf_busy);
endmodule

// File: rtl/spi_window_bridge.sv
module spi_window_bridge
  import spi_win_pkg::*;
#(
  parameter int NUM_CS  = 2,
  parameter int ADDR_W  = 8,
  parameter int CLK_DIV = 2,
  parameter int WE_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int IDX_W = $clog2(NUM_CS + 1);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [NUM_CS-1:0] user_mode, wr_allow;
  logic [31:0]       reg_rdata;
  logic              reg_wr_en;
  logic [IDX_W-1:0]  reg_idx;
  logic              shf_busy, shf_done, shf_start;
  logic [7:0]        shf_rx, shf_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  spi_win_regs #(.NUM_CS(NUM_CS), .WE_BASE(WE_BASE), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(reg_wr_en), .idx(reg_idx),
    .wr_data(bus_wdata), .rd_data(reg_rdata), .user_mode(user_mode),
    .wr_allow(wr_allow), .cs_n(spi_cs_n)
  );

  spi_win_seq #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .CS_W(CS_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .user_mode(user_mode),
    .wr_allow(wr_allow), .reg_rdata(reg_rdata), .reg_wr_en(reg_wr_en),
    .reg_idx(reg_idx), .shf_busy(shf_busy), .shf_done(shf_done),
    .shf_rx(shf_rx), .shf_start(shf_start), .shf_tx(shf_tx)
  );

  spi_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shf (
    .clk(clk), .rst_n(rst_sync_n), .start(shf_start), .tx_byte(shf_tx),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .busy(shf_busy),
    .done(shf_done), .rx_byte(shf_rx)
  );

  // R9: a chip that is not in user mode never has its select asserted
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs_chk
    assert_cs_needs_user_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !user_mode[g] |-> spi_cs_n[g]);
  end
endmodule

// File: tb/sim_spi_window_bridge.sv
module sim_spi_window_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [2:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, spi_sclk, spi_mosi, spi_miso;
  logic [1:0]  spi_cs_n;

  int n_checks = 0, n_fail = 0, cyc = 0;
  int xfer_cnt = 0, bitn = 0;
  logic [7:0] in_sh = '0;
  logic [7:0] tx_log [0:15];
  logic       pulse_ok;
  int         last_lat;

  localparam logic [7:0] A_CFG   = 8'h00;
  localparam logic [7:0] A_CTRL0 = 8'h04;
  localparam logic [7:0] A_CTRL1 = 8'h08;
  localparam logic [7:0] A_WIN0  = 8'h80;
  localparam logic [7:0] A_WIN1  = 8'hC0;

  always #4 clk = ~clk;

  spi_window_bridge u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  function automatic logic [7:0] resp(int k);
    return 8'(8'h5A + 37 * k);
  endfunction

  // mode-0 device: shifts MSB first, samples MOSI on rising SCLK
  assign spi_miso = resp(xfer_cnt)[7 - bitn];
  always @(posedge spi_sclk) begin
    if (bitn == 7) begin
      if (xfer_cnt < 16) tx_log[xfer_cnt] = {in_sh[6:0], spi_mosi};
      xfer_cnt = xfer_cnt + 1;
      bitn = 0;
    end else begin
      bitn = bitn + 1;
    end
    in_sh = {in_sh[6:0], spi_mosi};
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual cyc=%0d expected < 150000", cyc);
      finish_run();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    xfer_cnt = 0;
    bitn = 0;
  endtask

  task automatic access(input logic wr, input logic [7:0] addr, input logic [2:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    int lat = 0;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = addr; bus_size = sz; bus_wdata = wd;
    do begin
      @(negedge clk);
      lat++;
    end while (!bus_ready && lat < 5000);
    rd = bus_rdata;
    last_lat = lat;
    bus_valid = 1'b0;
    @(negedge clk);
    pulse_ok = !bus_ready;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    check("R1 cs_n", 32'(spi_cs_n), 32'h3);
    check("R1 ready", 32'(bus_ready), 32'h0);
    check("R1 sclk", 32'(spi_sclk), 32'h0);
    access(1'b0, A_CFG, 3'd4, 0, r);   check("R1 cfg", r, 32'h0);
    access(1'b0, A_CTRL0, 3'd4, 0, r); check("R1 ctrl0", r, 32'h0);
    access(1'b0, A_CTRL1, 3'd4, 0, r); check("R1 ctrl1", r, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] r;
    access(1'b1, A_CTRL0, 3'd4, 32'h3, r);
    access(1'b0, A_CTRL0, 3'd4, 0, r); check("R2 ctrl0 readback", r, 32'h3);
    access(1'b1, A_CFG, 3'd4, 32'h0001_0000, r);
    access(1'b0, A_CFG, 3'd4, 0, r);   check("R2 cfg readback", r, 32'h0001_0000);
    check("R9 cs0 low in user", 32'(spi_cs_n), 32'h2);
    access(1'b1, A_CTRL0, 3'd4, 32'h7, r);
    check("R9 stop deasserts", 32'(spi_cs_n), 32'h3);
    access(1'b1, A_CTRL1, 3'd4, 32'h1, r);
    check("R9 non-user mode high", 32'(spi_cs_n), 32'h3);
    access(1'b1, A_CTRL0, 3'd4, 32'h3, r);
  endtask

  task automatic t_reads();
    logic [31:0] r;
    clear_log();
    access(1'b0, A_WIN0, 3'd4, 0, r);
    check("R3 four transfers", xfer_cnt, 4);
    for (int i = 0; i < 4; i++) check("R3 dummy byte", 32'(tx_log[i]), 32'h0);
    check("R4 little-endian", r, {resp(3), resp(2), resp(1), resp(0)});
    clear_log();
    access(1'b0, A_WIN0, 3'd1, 0, r);
    check("R4 one byte", r, {24'h0, resp(0)});
    check("R11 pulse one cycle", 32'(pulse_ok), 32'h1);
    check("R11 latency", 32'(last_lat >= 32), 32'h1);
    check("R10 sclk idle", 32'(spi_sclk), 32'h0);
    clear_log();
    access(1'b0, A_WIN0, 3'd3, 0, r);
    check("R3 three transfers", xfer_cnt, 3);
    check("R4 three bytes", r, {8'h0, resp(2), resp(1), resp(0)});
  endtask

  task automatic t_writes();
    logic [31:0] r;
    clear_log();
    access(1'b1, A_WIN0, 3'd4, 32'h1122_3344, r);
    check("R5 count", xfer_cnt, 4);
    check("R5/R10 byte order", {tx_log[0], tx_log[1], tx_log[2], tx_log[3]}, 32'h4433_2211);
    clear_log();
    access(1'b1, A_WIN0, 3'd2, 32'hFFFF_A55A, r);
    check("R5 two bytes", {xfer_cnt[15:0], tx_log[0], tx_log[1]}, 32'h0002_5AA5);
    // WE only for chip 1 (bit 17): chip 0 store dropped
    access(1'b1, A_CFG, 3'd4, 32'h0002_0000, r);
    clear_log();
    access(1'b1, A_WIN0, 3'd4, 32'hDEAD_BEEF, r);
    check("R6 no WE no spi", xfer_cnt, 0);
    // chip 1 write-enabled but mode not user
    access(1'b1, A_CTRL1, 3'd4, 32'h2, r);
    clear_log();
    access(1'b1, A_WIN1, 3'd1, 32'h77, r);
    check("R7 non-user store dropped", xfer_cnt, 0);
    // chip 1 in user mode and enabled: R13 window slice reaches it
    access(1'b1, A_CTRL1, 3'd4, 32'h3, r);
    clear_log();
    access(1'b1, A_WIN1, 3'd1, 32'h77, r);
    check("R13/R6 chip1 store", {xfer_cnt[23:0], tx_log[0]}, 32'h0000_0177);
    access(1'b1, A_CFG, 3'd4, 32'h0001_0000, r);
    clear_log();
    access(1'b1, A_WIN0, 3'd1, 32'h3C, r);
    check("R6 bit16 enables chip0", {xfer_cnt[23:0], tx_log[0]}, 32'h0000_013C);
  endtask

  task automatic t_refused();
    logic [31:0] r;
    access(1'b1, A_CTRL1, 3'd4, 32'h0, r);
    clear_log();
    access(1'b0, A_WIN1, 3'd4, 0, r);
    check("R8 ones", r, 32'hFFFF_FFFF);
    check("R8 no spi", xfer_cnt, 0);
    clear_log();
    access(1'b0, A_WIN0, 3'd0, 0, r);
    check("R12 size0 ones", r, 32'hFFFF_FFFF);
    access(1'b0, A_WIN0, 3'd5, 0, r);
    check("R12 size5 ones", r, 32'hFFFF_FFFF);
    check("R12 no spi", xfer_cnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_regs();
    t_reads();
    t_writes();
    t_refused();
    finish_run();
  end
endmodule